// File: doc/BRIEF.md
# Linear Frequency Ramp Generator

This block produces the tuning word that drives a phase accumulator in a frequency synthesizer. It moves the word between two programmed limits, a lower frequency and an upper frequency, along a straight line. The line has a programmable step size and a programmable step interval, so a frequency-keyed signal changes gradually and does not jump. A direction input picks the limit the word moves toward. When the word reaches that limit it stays there until the direction changes.

Inside, the block keeps an offset from the lower limit in a frequency accumulator. The output word is the lower limit plus that offset. An interval timer fires one step every (rate + 1) clocks. A clear input zeroes the offset and restarts the timer, so that a sweep begins exactly at the lower limit. Step size, rate and limits are read live. Software can rewrite them while a sweep runs to build a piecewise nonlinear frequency profile.

Top module: `ramp_fsk_sweeper`

## Requirements
- R1: While the synchronous active-high reset is applied, and after it is released, the accumulator offset is zero, so tune_word equals lo_word, and the interval timer is at zero.
- R2: With ramp_up high, every step adds step_word to the offset, and tune_word rises by step_word.
- R3: With ramp_up low, every step subtracts step_word from the offset, and tune_word falls by step_word.
- R4: An upward step that would reach or pass hi_word sets tune_word to exactly hi_word. Later upward steps leave it there, and this dwell lasts as long as ramp_up stays high.
- R5: A downward step of at least the current offset sets tune_word to exactly lo_word. Later downward steps leave it there.
- R6: The interval timer fires when it is at zero and then reloads rate_word, so one step occurs every (rate_word + 1) clocks. A rate_word of 0 gives a step on every clock. Between steps the offset does not change.
- R7: While acc_clr is high, the offset and the interval timer are forced to zero and tune_word equals lo_word. The first step comes on the first clock edge after acc_clr falls.
- R8: A new step_word applies on the next step. A new rate_word applies from the next reload of the timer, so the interval that is already running is not cut short.
- R9: tune_word is lo_word plus the offset, computed without registering. If hi_word is lowered below the current word, the next upward step clamps to the new hi_word.
- R10: Arithmetic uses the full 48-bit width without wrap-around. Steps as large as half the range still clamp correctly at hi_word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_clr | input | 1 | Clears the frequency accumulator and the interval timer while high |
| ramp_up | input | 1 | 1 ramps toward hi_word, 0 ramps toward lo_word |
| lo_word | input | 48 | Lower limit tuning word (F1), must not exceed hi_word |
| hi_word | input | 48 | Upper limit tuning word (F2) |
| step_word | input | 48 | Positive frequency increment per step |
| rate_word | input | 20 | Step interval minus one, in clocks |
| tune_word | output | 48 | Current tuning word |

## Verification
The hardest case to reach is a change of rate_word that lands in the middle of a running interval. The old interval must finish before the new rate applies. To reach it, the stimulus switches the rate in the cycle just after a reload, while the timer still holds the long count. The bench then samples at the exact clock where each step is due. Overshoot at both limits is driven the same way: the step sizes are chosen so they do not divide the span evenly. A separate case lowers hi_word below the live word mid-sweep. Another case uses steps of half the 48-bit range, so the sum would overflow without the extra carry bit.

// File: rtl/ramp_fsk_pkg.sv
package ramp_fsk_pkg;

    localparam int DEF_FREQ_W = 48;
    localparam int DEF_RATE_W = 20;

    typedef enum logic {
        DIR_TOWARD_LO = 1'b0,
        DIR_TOWARD_HI = 1'b1
    } ramp_dir_e;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_STEP  = 2'd2
    } accum_act_e;

endpackage

// File: rtl/ramp_interval_timer.sv
module ramp_interval_timer #(
    parameter int RATE_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    logic [RATE_W-1:0] cnt;

    assign tick = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= rate;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // R6
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr) |=> (cnt == $past(rate)));

    // R8
    countdown_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr) |=> (cnt == $past(cnt) - 1'b1));

    // R7
    clear_timer_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> tick);

endmodule

// File: rtl/ramp_freq_accum.sv
module ramp_freq_accum
    import ramp_fsk_pkg::*;
#(
    parameter int FREQ_W = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              tick,
    input  ramp_dir_e         dir,
    input  logic [FREQ_W-1:0] step,
    input  logic [FREQ_W-1:0] span,
    output logic [FREQ_W-1:0] offset
);
    localparam int EXT_W = FREQ_W + 1;

    logic [EXT_W-1:0]  up_sum;
    logic [FREQ_W-1:0] up_next;
    logic [FREQ_W-1:0] dn_next;
    logic [FREQ_W-1:0] step_next;
    accum_act_e        act;

    assign up_sum  = {1'b0, offset} + {1'b0, step};
    assign up_next = (up_sum >= {1'b0, span}) ? span : up_sum[FREQ_W-1:0];
    assign dn_next = (offset <= step) ? '0 : (offset - step);

    always_comb begin
        if (clr) begin
            act = ACT_CLEAR;
        end else if (tick) begin
            act = ACT_STEP;
        end else begin
            act = ACT_HOLD;
        end
    end

    always_comb begin
        if (dir == DIR_TOWARD_HI) begin
            step_next = up_next;
        end else begin
            step_next = dn_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            offset <= '0;
        end else begin
            case (act)
                ACT_CLEAR: offset <= '0;
                ACT_STEP:  offset <= step_next;
                default:   offset <= offset;
            endcase
        end
    end

    // R4
    upper_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr && dir == DIR_TOWARD_HI) |=> (offset <= $past(span)));

    // R5
    descend_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr && dir == DIR_TOWARD_LO) |=> (offset <= $past(offset)));

    // R2
    ascend_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr && dir == DIR_TOWARD_HI && offset <= span) |=> (offset >= $past(offset)));

    // R6
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr) |=> $stable(offset));

    // R7
    clear_accum_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (offset == '0));

endmodule

// File: rtl/ramp_fsk_sweeper.sv
module ramp_fsk_sweeper
    import ramp_fsk_pkg::*;
#(
    parameter int FREQ_W = DEF_FREQ_W,
    parameter int RATE_W = DEF_RATE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_clr,
    input  logic              ramp_up,
    input  logic [FREQ_W-1:0] lo_word,
    input  logic [FREQ_W-1:0] hi_word,
    input  logic [FREQ_W-1:0] step_word,
    input  logic [RATE_W-1:0] rate_word,
    output logic [FREQ_W-1:0] tune_word
);
    logic              step_tick;
    logic [FREQ_W-1:0] span;
    logic [FREQ_W-1:0] offset;
    ramp_dir_e         dir;

    assign span = hi_word - lo_word;
    assign dir  = ramp_up ? DIR_TOWARD_HI : DIR_TOWARD_LO;

    ramp_interval_timer #(
        .RATE_W (RATE_W)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .clr  (acc_clr),
        .rate (rate_word),
        .tick (step_tick)
    );

    ramp_freq_accum #(
        .FREQ_W (FREQ_W)
    ) u_accum (
        .clk    (clk),
        .rst    (rst),
        .clr    (acc_clr),
        .tick   (step_tick),
        .dir    (dir),
        .step   (step_word),
        .span   (span),
        .offset (offset)
    );

    assign tune_word = lo_word + offset;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (tune_word == lo_word));

endmodule

// File: tb/ramp_fsk_sweeper_test.sv
`timescale 1ns/1ps
module ramp_fsk_sweeper_test;

    localparam int FW = 48;
    localparam int RW = 20;
    localparam int NV = 15;

    typedef struct packed {
        logic          up;
        logic [FW-1:0] step;
        logic [RW-1:0] rate;
        logic [7:0]    cycles;
        logic [FW-1:0] expect_word;
    } vec_t;

    // lo = 1000, hi = 2000 throughout the table; rows run back to back
    localparam vec_t TBL [NV] = '{
        '{1'b1, 48'd100,  20'd0, 8'd3, 48'd1300},  // R2 three steps up
        '{1'b1, 48'd100,  20'd0, 8'd8, 48'd2000},  // R4 clamp at hi
        '{1'b1, 48'd100,  20'd0, 8'd5, 48'd2000},  // R4 dwell at hi
        '{1'b0, 48'd250,  20'd0, 8'd2, 48'd1500},  // R3 two steps down
        '{1'b0, 48'd250,  20'd3, 8'd1, 48'd1250},  // R6 tick then reload 3
        '{1'b0, 48'd250,  20'd3, 8'd3, 48'd1250},  // R6 no step inside interval
        '{1'b0, 48'd250,  20'd3, 8'd1, 48'd1000},  // R6 step after rate+1
        '{1'b0, 48'd250,  20'd3, 8'd8, 48'd1000},  // R5 dwell at lo
        '{1'b1, 48'd300,  20'd3, 8'd4, 48'd1300},  // R8 new step size
        '{1'b1, 48'd300,  20'd1, 8'd3, 48'd1300},  // R8 old interval completes
        '{1'b1, 48'd300,  20'd1, 8'd1, 48'd1600},  // R8 step at old reload
        '{1'b1, 48'd300,  20'd1, 8'd2, 48'd1900},  // R8 new rate applies
        '{1'b1, 48'd300,  20'd1, 8'd2, 48'd2000},  // R4 overshoot clamp
        '{1'b1, 48'd1,    20'd1, 8'd2, 48'd2000},  // R4 dwell
        '{1'b0, 48'd5000, 20'd0, 8'd2, 48'd1000}   // R5 large down step clamps
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          acc_clr = 1'b0;
    logic          ramp_up = 1'b1;
    logic [FW-1:0] lo_word = 48'd1000;
    logic [FW-1:0] hi_word = 48'd2000;
    logic [FW-1:0] step_word = 48'd100;
    logic [RW-1:0] rate_word = 20'd0;
    logic [FW-1:0] tune_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ramp_fsk_sweeper uut (
        .clk       (clk),
        .rst       (rst),
        .acc_clr   (acc_clr),
        .ramp_up   (ramp_up),
        .lo_word   (lo_word),
        .hi_word   (hi_word),
        .step_word (step_word),
        .rate_word (rate_word),
        .tune_word (tune_word)
    );

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [FW-1:0] expv);
        checks++;
        if (tune_word !== expv) begin
            errors++;
            $display("FAIL %s tune_word actual %0h expected %0h", req, tune_word, expv);
        end
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        run(2);
        check("R1", 48'd1000);
        rst = 1'b0;
        check("R1", 48'd1000);

        for (int i = 0; i < NV; i++) begin
            ramp_up   = TBL[i].up;
            step_word = TBL[i].step;
            rate_word = TBL[i].rate;
            run(int'(TBL[i].cycles));
            check($sformatf("R2-R8 row %0d", i), TBL[i].expect_word);
        end

        // R7: clear mid-ramp
        ramp_up = 1'b1; step_word = 48'd100; rate_word = 20'd0;
        run(3);
        check("R2", 48'd1300);
        acc_clr = 1'b1;
        run(1);
        check("R7", 48'd1000);
        run(3);
        check("R7", 48'd1000);
        acc_clr = 1'b0;
        run(1);
        check("R7", 48'd1100);

        // R9: lower hi below current word, next up step clamps to new hi
        run(4);
        check("R9", 48'd1500);
        hi_word = 48'd1300;
        check("R9", 48'd1500);
        run(1);
        check("R9", 48'd1300);

        // R9: lo change shows on output without a clock
        lo_word = 48'd900;
        #0.5;
        check("R9", 48'd1200);
        @(negedge clk);

        // R1: reset mid-run
        rst = 1'b1;
        run(1);
        check("R1", 48'd900);
        rst = 1'b0;

        // R10: wide values
        lo_word   = 48'h1000_0000_0000;
        hi_word   = 48'hFFFF_FFFF_FFFF;
        step_word = 48'h8000_0000_0000;
        acc_clr = 1'b1;
        run(1);
        acc_clr = 1'b0;
        run(1);
        check("R10", 48'h9000_0000_0000);
        run(1);
        check("R10", 48'hFFFF_FFFF_FFFF);
        ramp_up = 1'b0;
        run(1);
        check("R10", 48'h7FFF_FFFF_FFFF);
        run(1);
        check("R10", 48'h1000_0000_0000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule